// File: doc/BRIEF.md
# ATA Channel Task-File Register Front End

This block holds the host-visible register file of one ATA channel that carries two drive slots. It decodes a byte-wide host bus. Three address groups belong to the channel: the eight-byte command block, the two-byte control group and the eight-byte bus-master group. Any other address is a miss. Each slot keeps its own sector count, sector number and cylinder pair. The error, features, drive/head, status, command and device-control registers are shared by the whole channel.

The kind of drive in each slot is a static input: none, disk or packet device. The block carries out the software-reset handshake on the device-control register. It applies fixed substitution rules when the selected slot is empty, and it gates host interrupts with the interrupt-disable bit. A separate command engine runs the commands. That engine sees the register values on output ports and a one-cycle strobe for each command write. It can load status and can request an interrupt. Data-port traffic and bus-master registers belong to other blocks. Bus-master hits are only flagged.

Top module: `ata_taskfile_regs`

## Requirements
- R1: After reset the error register is 0x01, drive/head 0x00, status 0x00, command 0x00 and device control 0x08. Both slots hold sector count 1, sector number 1 and cylinder 0x0000. The interrupt is low.
- R2: The channel claims three address groups. The command block is the address masked with 0xFFF8 equal to CMD_BASE (default 0x1F0). The control group is the address masked with 0xFFFE equal to CTRL_BASE (default 0x3F6). The bus-master group is the address masked with 0xFFF8 equal to DMA_BASE (default 0xC000). Any other access is a miss: a write to it changes nothing, a read of it returns 0, and addr_err is high in the cycle after the access. dma_hit is high, without delay, while an access falls in the bus-master group, and such an access returns 0.
- R3: A control write whose bit 2 (soft reset) goes from 0 to 1 loads status 0x90, error 0x01 and command 0x00. It stores the written control byte with bit 1 (interrupt disable) forced to 0, and it drops a pending interrupt.
- R4: A control write that keeps bit 2 at 1 does not repeat the reset. The status register keeps its value.
- R5: A control write that takes bit 2 from 1 to 0 clears status bit 7 (busy), sets status bit 6 (ready) and clears drive/head bits 3:0. Every slot then reloads sector count 1 and sector number 1. Its cylinder reloads 0xEB14 (high byte 0xEB) for a packet device and 0x0000 for any other kind.
- R6: A drive/head write (command-block offset 6) stores the byte ORed with 0xA0. Bit 4 selects slot 1. If the newly selected slot is empty, error bit 2 (abort) and status bit 0 (error) are set. Otherwise both are left unchanged.
- R7: A read at command-block offset 1 returns the error register. A write there stores the features byte, which is seen only on the feature port.
- R8: A read of the control-group address with bit 0 set returns 0xFF in every state.
- R9: While the selected slot is empty, a drive/head read returns 0xA0. Every other command-block read and the alternate-status read return 0.
- R10: Writes at offsets 2 to 5 (sector count, sector number, cylinder low, cylinder high) go to the selected slot only. Reads return that slot's values.
- R11: A write at command-block offset 7 loads the command byte and raises cmd_strobe for exactly the following cycle.
- R12: An engine interrupt request sets the irq level only while control bit 1 is 0. The level holds until a status read at offset 7 or a soft-reset rise. The alternate-status read at the control address with bit 0 clear returns status and leaves the level alone.
- R13: Read data appears on rdata in the cycle after rd_en and is 0 in any cycle that follows no read. eng_status_we loads the status register in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Host byte address |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Registered read byte |
| addr_err | output | 1 | Previous access hit no claimed address |
| dma_hit | output | 1 | Current access falls in the bus-master group |
| slot_kind | input | 2x2 | Per-slot kind: 00 none, 01 disk, 10 packet |
| eng_status_we | input | 1 | Engine loads status |
| eng_status | input | 8 | Engine status byte |
| eng_irq | input | 1 | Engine interrupt request |
| irq | output | 1 | Host interrupt level |
| cmd_strobe | output | 1 | One-cycle pulse after a command write |
| cmd_code | output | 8 | Command register |
| feature | output | 8 | Features register |
| dev_head | output | 8 | Drive/head register |
| status | output | 8 | Status register |
| error | output | 8 | Error register |
| dev_ctrl | output | 8 | Device-control register |
| sel_count | output | 8 | Sector count of the selected slot |
| sel_secnum | output | 8 | Sector number of the selected slot |
| sel_cyl | output | 16 | Cylinder of the selected slot |

## Verification
Every register write, the addr_err flag, cmd_strobe and the irq level take effect one clock edge after the access. Read data also lands on rdata one edge after rd_en. The only exception is dma_hit, which follows the address within the same cycle. The bench applies each access on a falling edge and removes it on the next falling edge. It samples registered results at that second falling edge, and it samples dma_hit while the access is still being driven. Random slot traffic is compared with a bench model that is updated only when an access completes.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int SLOTS = 2;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_DISK   = 2'b01,
        KIND_PACKET = 2'b10
    } slot_kind_e;

    // command-block offsets
    localparam logic [2:0] OFF_DATA  = 3'd0;
    localparam logic [2:0] OFF_FEAT  = 3'd1;
    localparam logic [2:0] OFF_COUNT = 3'd2;
    localparam logic [2:0] OFF_SNUM  = 3'd3;
    localparam logic [2:0] OFF_CYLLO = 3'd4;
    localparam logic [2:0] OFF_CYLHI = 3'd5;
    localparam logic [2:0] OFF_DH    = 3'd6;
    localparam logic [2:0] OFF_CMD   = 3'd7;

    // bit positions
    localparam int CTL_SRST = 2;
    localparam int CTL_NIEN = 1;
    localparam int ST_BSY   = 7;
    localparam int ST_DRDY  = 6;
    localparam int ST_ERR   = 0;
    localparam int ERR_ABRT = 2;
    localparam int DH_SLOT  = 4;

    // constant values
    localparam logic [7:0] DH_FIXED   = 8'hA0;
    localparam logic [7:0] ST_RESET   = 8'h90;
    localparam logic [7:0] ERR_INIT   = 8'h01;
    localparam logic [7:0] CTL_INIT   = 8'h08;
    localparam logic [7:0] ALT_FILL   = 8'hFF;

    typedef struct packed {
        logic       cmd_blk;
        logic       ctl;
        logic       alt;
        logic       dma;
        logic       miss;
        logic [2:0] off;
    } dec_t;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMD_BASE  = 16'h01F0,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h03F6,
    parameter logic [ADDR_W-1:0] DMA_BASE  = 16'hC000,
    parameter int              CMD_SPAN  = 8,
    parameter int              CTRL_SPAN = 2,
    parameter int              DMA_SPAN  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] CMD_MASK  = ~(ADDR_W'(CMD_SPAN - 1));
    localparam logic [ADDR_W-1:0] CTRL_MASK = ~(ADDR_W'(CTRL_SPAN - 1));
    localparam logic [ADDR_W-1:0] DMA_MASK  = ~(ADDR_W'(DMA_SPAN - 1));

    logic hit_cmd, hit_ctl_grp, hit_dma;

    always_comb begin
        hit_cmd     = (addr & CMD_MASK) == CMD_BASE;
        hit_ctl_grp = (addr & CTRL_MASK) == CTRL_BASE;
        hit_dma     = (addr & DMA_MASK) == DMA_BASE;
        dec.cmd_blk = hit_cmd;
        dec.ctl     = hit_ctl_grp && !addr[0];
        dec.alt     = hit_ctl_grp && addr[0];
        dec.dma     = hit_dma;
        dec.miss    = !(hit_cmd || hit_ctl_grp || hit_dma);
        dec.off     = addr[2:0];
    end
endmodule

// File: rtl/ata_tf_slot.sv
module ata_tf_slot
    import ata_tf_pkg::*;
#(
    parameter int              DW      = 8,
    parameter logic [2*DW-1:0] PKT_CYL = 16'hEB14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    kind,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [DW-1:0] wdata,
    input  logic          reload,
    output logic [DW-1:0] count,
    output logic [DW-1:0] secnum,
    output logic [2*DW-1:0] cyl
);
    typedef struct packed {
        logic [DW-1:0] count;
        logic [DW-1:0] secnum;
        logic [DW-1:0] cyl_lo;
        logic [DW-1:0] cyl_hi;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reload) begin
            s_d.count  = DW'(1);
            s_d.secnum = DW'(1);
            if (kind == KIND_PACKET) begin
                {s_d.cyl_hi, s_d.cyl_lo} = PKT_CYL;
            end else begin
                {s_d.cyl_hi, s_d.cyl_lo} = '0;
            end
        end else if (wr_en) begin
            case (wr_off)
                OFF_COUNT: s_d.count  = wdata;
                OFF_SNUM:  s_d.secnum = wdata;
                OFF_CYLLO: s_d.cyl_lo = wdata;
                OFF_CYLHI: s_d.cyl_hi = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count  <= DW'(1);
            s_q.secnum <= DW'(1);
            s_q.cyl_lo <= '0;
            s_q.cyl_hi <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count  = s_q.count;
    assign secnum = s_q.secnum;
    assign cyl    = {s_q.cyl_hi, s_q.cyl_lo};

    // R5: reload restores the counters
    a_r5_reload_counts: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == DW'(1)) && (secnum == DW'(1)));

    // R5: packet slots take the signature cylinder
    a_r5_packet_cyl: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && kind == KIND_PACKET) |=> (cyl == PKT_CYL));
endmodule

// File: rtl/ata_tf_irq.sv
module ata_tf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic nien,
    input  logic rst_clr,
    input  logic rd_clr,
    output logic irq
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (rst_clr) begin
            pend_d = 1'b0;
        end else if (req && !nien) begin
            pend_d = 1'b1;
        end else if (rd_clr) begin
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign irq = pend_q;

    // R12: a new interrupt needs an enabled request
    a_r12_gated_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(req && !nien));

    // R12: level holds until cleared
    a_r12_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_clr && !rst_clr) |=> irq);

    // R3: soft reset drops the interrupt
    a_r3_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rst_clr |=> !irq);
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
    import ata_tf_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DW        = 8,
    parameter logic [ADDR_W-1:0] CMD_BASE  = 16'h01F0,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h03F6,
    parameter logic [ADDR_W-1:0] DMA_BASE  = 16'hC000,
    parameter logic [2*DW-1:0]   PKT_CYL   = 16'hEB14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic                       addr_err,
    output logic                       dma_hit,
    input  logic [SLOTS-1:0][1:0]      slot_kind,
    input  logic                       eng_status_we,
    input  logic [DW-1:0]              eng_status,
    input  logic                       eng_irq,
    output logic                       irq,
    output logic                       cmd_strobe,
    output logic [DW-1:0]              cmd_code,
    output logic [DW-1:0]              feature,
    output logic [DW-1:0]              dev_head,
    output logic [DW-1:0]              status,
    output logic [DW-1:0]              error,
    output logic [DW-1:0]              dev_ctrl,
    output logic [DW-1:0]              sel_count,
    output logic [DW-1:0]              sel_secnum,
    output logic [2*DW-1:0]            sel_cyl
);
    typedef struct packed {
        logic [DW-1:0] error;
        logic [DW-1:0] feat;
        logic [DW-1:0] dh;
        logic [DW-1:0] status;
        logic [DW-1:0] cmd;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] rdata;
        logic          addr_err;
        logic          cmd_stb;
    } chan_t;

    chan_t n_d, c_q;
    dec_t  dec;

    logic [DW-1:0]   s_cnt [SLOTS];
    logic [DW-1:0]   s_sn  [SLOTS];
    logic [2*DW-1:0] s_cyl [SLOTS];

    logic          wr_blk, wr_ctl, rd_blk;
    logic          srst_rise, srst_fall, status_rd;
    logic          sel;
    logic          sel_present;
    logic [DW-1:0] rd_val;

    ata_tf_decode #(
        .ADDR_W   (ADDR_W),
        .CMD_BASE (CMD_BASE),
        .CTRL_BASE(CTRL_BASE),
        .DMA_BASE (DMA_BASE),
        .CMD_SPAN (8),
        .CTRL_SPAN(2),
        .DMA_SPAN (8)
    ) u_decode (
        .addr(addr),
        .dec (dec)
    );

    always_comb begin
        sel         = c_q.dh[DH_SLOT];
        sel_present = slot_kind[sel] != KIND_NONE;
        wr_blk      = wr_en && dec.cmd_blk;
        wr_ctl      = wr_en && dec.ctl;
        rd_blk      = rd_en && dec.cmd_blk;
        srst_rise   = wr_ctl && wdata[CTL_SRST] && !c_q.ctrl[CTL_SRST];
        srst_fall   = wr_ctl && !wdata[CTL_SRST] && c_q.ctrl[CTL_SRST];
        status_rd   = rd_blk && (dec.off == OFF_CMD);
    end

    genvar gi;
    generate
        for (gi = 0; gi < SLOTS; gi++) begin : g_slot
            logic slot_we;
            assign slot_we = wr_blk && (sel == gi[0]) &&
                             (dec.off >= OFF_COUNT) && (dec.off <= OFF_CYLHI);
            ata_tf_slot #(
                .DW     (DW),
                .PKT_CYL(PKT_CYL)
            ) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .kind  (slot_kind[gi]),
                .wr_en (slot_we),
                .wr_off(dec.off),
                .wdata (wdata),
                .reload(srst_fall),
                .count (s_cnt[gi]),
                .secnum(s_sn[gi]),
                .cyl   (s_cyl[gi])
            );
        end
    endgenerate

    ata_tf_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (eng_irq),
        .nien   (c_q.ctrl[CTL_NIEN]),
        .rst_clr(srst_rise),
        .rd_clr (status_rd),
        .irq    (irq)
    );

    // read multiplexer with empty-slot substitution
    always_comb begin
        rd_val = '0;
        if (dec.alt) begin
            rd_val = ALT_FILL;
        end else if ((dec.cmd_blk || dec.ctl) && !sel_present) begin
            rd_val = (dec.cmd_blk && dec.off == OFF_DH) ? DH_FIXED : '0;
        end else if (dec.ctl) begin
            rd_val = c_q.status;
        end else if (dec.cmd_blk) begin
            case (dec.off)
                OFF_FEAT:  rd_val = c_q.error;
                OFF_COUNT: rd_val = s_cnt[sel];
                OFF_SNUM:  rd_val = s_sn[sel];
                OFF_CYLLO: rd_val = s_cyl[sel][DW-1:0];
                OFF_CYLHI: rd_val = s_cyl[sel][2*DW-1:DW];
                OFF_DH:    rd_val = c_q.dh;
                OFF_CMD:   rd_val = c_q.status;
                default:   rd_val = '0;
            endcase
        end
    end

    // next-state of the channel registers
    always_comb begin
        n_d          = c_q;
        n_d.cmd_stb  = 1'b0;
        n_d.addr_err = (wr_en || rd_en) && dec.miss;
        n_d.rdata    = rd_en ? rd_val : '0;

        if (eng_status_we) begin
            n_d.status = eng_status;
        end

        if (wr_ctl) begin
            n_d.ctrl = wdata;
            if (srst_rise) begin
                n_d.status         = ST_RESET;
                n_d.error          = ERR_INIT;
                n_d.cmd            = '0;
                n_d.ctrl[CTL_NIEN] = 1'b0;
            end
            if (srst_fall) begin
                n_d.status[ST_BSY]  = 1'b0;
                n_d.status[ST_DRDY] = 1'b1;
                n_d.dh[3:0]         = 4'h0;
            end
        end

        if (wr_blk) begin
            case (dec.off)
                OFF_FEAT: n_d.feat = wdata;
                OFF_DH: begin
                    n_d.dh = wdata | DH_FIXED;
                    if (slot_kind[wdata[DH_SLOT]] == KIND_NONE) begin
                        n_d.error[ERR_ABRT] = 1'b1;
                        n_d.status[ST_ERR]  = 1'b1;
                    end
                end
                OFF_CMD: begin
                    n_d.cmd     = wdata;
                    n_d.cmd_stb = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.error    <= ERR_INIT;
            c_q.feat     <= '0;
            c_q.dh       <= '0;
            c_q.status   <= '0;
            c_q.cmd      <= '0;
            c_q.ctrl     <= CTL_INIT;
            c_q.rdata    <= '0;
            c_q.addr_err <= 1'b0;
            c_q.cmd_stb  <= 1'b0;
        end else begin
            c_q <= n_d;
        end
    end

    assign rdata      = c_q.rdata;
    assign addr_err   = c_q.addr_err;
    assign dma_hit    = (wr_en || rd_en) && dec.dma;
    assign cmd_strobe = c_q.cmd_stb;
    assign cmd_code   = c_q.cmd;
    assign feature    = c_q.feat;
    assign dev_head   = c_q.dh;
    assign status     = c_q.status;
    assign error      = c_q.error;
    assign dev_ctrl   = c_q.ctrl;
    assign sel_count  = s_cnt[sel];
    assign sel_secnum = s_sn[sel];
    assign sel_cyl    = s_cyl[sel];

    // R3: reset rise loads the fixed reset values
    a_r3_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        srst_rise |=> (status == ST_RESET) && (error == ERR_INIT) &&
                      (cmd_code == '0) && !dev_ctrl[CTL_NIEN]);

    // R6: drive/head always carries the fixed bits after a write
    a_r6_dh_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.cmd_blk && dec.off == OFF_DH) |=> (dev_head[7] && dev_head[5]));

    // R11: the strobe follows a command write only
    a_r11_strobe_src: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> $past(wr_en && addr == CMD_BASE + ADDR_W'(7)));

    // R2: a miss flag follows an access
    a_r2_miss_src: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> $past(wr_en || rd_en));

    // R8: the alternate address always reads all ones
    a_r8_alt_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.alt) |=> (rdata == ALT_FILL));
endmodule

// File: tb/ata_taskfile_regs_bench.sv
`timescale 1ns/1ps
module ata_taskfile_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        addr_err, dma_hit;
    logic [1:0][1:0] slot_kind;
    logic        eng_status_we = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        eng_irq = 1'b0;
    logic        irq, cmd_strobe;
    logic [7:0]  cmd_code, feature, dev_head, status, error, dev_ctrl;
    logic [7:0]  sel_count, sel_secnum;
    logic [15:0] sel_cyl;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    // bench model of the slot registers
    logic [7:0] m_cnt [2];
    logic [7:0] m_sn  [2];
    logic [7:0] m_cl  [2];
    logic [7:0] m_ch  [2];
    logic [7:0] m_dh;

    always #2.5 clk = ~clk;

    ata_taskfile_regs u_ata_taskfile_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .addr_err(addr_err), .dma_hit(dma_hit),
        .slot_kind(slot_kind), .eng_status_we(eng_status_we),
        .eng_status(eng_status), .eng_irq(eng_irq), .irq(irq),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .feature(feature),
        .dev_head(dev_head), .status(status), .error(error),
        .dev_ctrl(dev_ctrl), .sel_count(sel_count), .sel_secnum(sel_secnum),
        .sel_cyl(sel_cyl)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic eng_load(input logic [7:0] s);
        @(negedge clk);
        eng_status = s; eng_status_we = 1'b1;
        @(negedge clk);
        eng_status_we = 1'b0;
    endtask

    task automatic eng_pulse();
        @(negedge clk);
        eng_irq = 1'b1;
        @(negedge clk);
        eng_irq = 1'b0;
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] off);
        logic s;
        s = m_dh[4];
        case (off)
            3'd2: return m_cnt[s];
            3'd3: return m_sn[s];
            3'd4: return m_cl[s];
            3'd5: return m_ch[s];
            default: return m_dh;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        slot_kind[0] = 2'b01;
        slot_kind[1] = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 power-up state
        chk("R1 ctrl", dev_ctrl, 8'h08);
        chk("R1 status", status, 8'h00);
        chk("R1 dh", dev_head, 8'h00);
        chk("R1 irq", irq, 1'b0);
        bus_rd(16'h01F1, rv); chk("R1 error", rv, 8'h01);
        bus_rd(16'h01F2, rv); chk("R1 count", rv, 8'h01);
        bus_rd(16'h01F3, rv); chk("R1 secnum", rv, 8'h01);
        bus_rd(16'h01F4, rv); chk("R1 cyl lo", rv, 8'h00);
        bus_rd(16'h01F5, rv); chk("R1 cyl hi", rv, 8'h00);
        bus_rd(16'h01F7, rv); chk("R1 status rd", rv, 8'h00);

        // R8 alternate address
        bus_rd(16'h03F7, rv); chk("R8 alt", rv, 8'hFF);

        // R7 features versus error
        bus_wr(16'h01F1, 8'h5A);
        chk("R7 feature", feature, 8'h5A);
        bus_rd(16'h01F1, rv); chk("R7 error read", rv, 8'h01);

        // R2 decode misses and bus-master group
        bus_wr(16'h0171, 8'h33);
        chk("R2 miss err wr", addr_err, 1'b1);
        chk("R2 miss ignored", feature, 8'h5A);
        bus_rd(16'h0177, rv);
        chk("R2 miss rd", rv, 8'h00);
        chk("R2 miss err rd", addr_err, 1'b1);
        @(negedge clk);
        addr = 16'hC002; rd_en = 1'b1;
        #1 chk("R2 dma hit", dma_hit, 1'b1);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 dma rd", rdata, 8'h00);
        chk("R2 dma no err", addr_err, 1'b0);
        @(negedge clk);
        addr = 16'hC00A; rd_en = 1'b1;
        #1 chk("R2 other dma", dma_hit, 1'b0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 other dma err", addr_err, 1'b1);
        // R13 idle cycle clears rdata
        bus_rd(16'h03F7, rv);
        @(negedge clk);
        chk("R13 idle rdata", rdata, 8'h00);

        // R10 random slot traffic against the model
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = 8'h01; m_sn[i] = 8'h01; m_cl[i] = 8'h00; m_ch[i] = 8'h00;
        end
        m_dh = 8'h00;
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [7:0] v;
            logic [2:0] off;
            op = int'($urandom_range(0, 2));
            v  = 8'($urandom);
            if (op == 0) begin
                bus_wr(16'h01F6, v);
                m_dh = v | 8'hA0;
                chk("R6 dh or", dev_head, m_dh);
            end else if (op == 1) begin
                off = 3'($urandom_range(2, 5));
                bus_wr(16'h01F0 + 16'(off), v);
                case (off)
                    3'd2: m_cnt[m_dh[4]] = v;
                    3'd3: m_sn[m_dh[4]]  = v;
                    3'd4: m_cl[m_dh[4]]  = v;
                    default: m_ch[m_dh[4]] = v;
                endcase
            end else begin
                off = 3'($urandom_range(2, 6));
                bus_rd(16'h01F0 + 16'(off), rv);
                chk("R10 slot read", rv, model_rd(off));
            end
        end
        chk("R10 error untouched", error, 8'h01);

        // R11 command strobe
        bus_wr(16'h01F7, 8'hEC);
        chk("R11 strobe", cmd_strobe, 1'b1);
        chk("R11 code", cmd_code, 8'hEC);
        @(negedge clk);
        chk("R11 strobe drop", cmd_strobe, 1'b0);

        // R12 interrupt level and gating
        eng_pulse();
        chk("R12 raise", irq, 1'b1);
        bus_rd(16'h03F6, rv);
        chk("R12 alt keeps", irq, 1'b1);
        bus_rd(16'h01F7, rv);
        chk("R12 status clears", irq, 1'b0);
        bus_wr(16'h03F6, 8'h02);
        eng_pulse();
        chk("R12 gated", irq, 1'b0);
        bus_wr(16'h03F6, 8'h00);

        // R13 engine status load
        eng_load(8'h50);
        bus_rd(16'h01F7, rv); chk("R13 eng status", rv, 8'h50);

        // R3 reset rise
        eng_pulse();
        bus_wr(16'h03F6, 8'h06);
        chk("R3 status", status, 8'h90);
        chk("R3 error", error, 8'h01);
        chk("R3 cmd", cmd_code, 8'h00);
        chk("R3 ctrl", dev_ctrl, 8'h04);
        chk("R3 irq", irq, 1'b0);

        // R4 held reset bit
        eng_load(8'h81);
        bus_wr(16'h03F6, 8'h04);
        chk("R4 no repeat", status, 8'h81);

        bus_wr(16'h01F6, 8'h1F);
        bus_wr(16'h01F4, 8'h12);
        bus_wr(16'h01F6, 8'h0F);
        bus_wr(16'h01F2, 8'h77);
        bus_wr(16'h01F6, 8'h1F);

        // R5 reset fall
        bus_wr(16'h03F6, 8'h00);
        chk("R5 status", status, 8'h41);
        chk("R5 head", dev_head, 8'hB0);
        bus_rd(16'h01F4, rv); chk("R5 pkt cyl lo", rv, 8'h14);
        bus_rd(16'h01F5, rv); chk("R5 pkt cyl hi", rv, 8'hEB);
        bus_rd(16'h01F2, rv); chk("R5 pkt count", rv, 8'h01);
        bus_rd(16'h01F3, rv); chk("R5 pkt secnum", rv, 8'h01);
        bus_wr(16'h01F6, 8'h00);
        bus_rd(16'h01F4, rv); chk("R5 disk cyl lo", rv, 8'h00);
        bus_rd(16'h01F5, rv); chk("R5 disk cyl hi", rv, 8'h00);
        bus_rd(16'h01F2, rv); chk("R5 disk count", rv, 8'h01);

        // R6 present selection leaves error bits
        eng_load(8'h40);
        bus_wr(16'h01F6, 8'h10);
        chk("R6 present status", status, 8'h40);
        chk("R6 present error", error, 8'h01);

        // R6 and R9 empty slot
        slot_kind[1] = 2'b00;
        bus_wr(16'h01F6, 8'h00);
        bus_wr(16'h01F6, 8'h10);
        chk("R6 empty dh", dev_head, 8'hB0);
        chk("R6 abort", error, 8'h05);
        chk("R6 err bit", status, 8'h41);
        bus_rd(16'h01F6, rv); chk("R9 dh sub", rv, 8'hA0);
        bus_rd(16'h01F1, rv); chk("R9 error sub", rv, 8'h00);
        bus_rd(16'h01F7, rv); chk("R9 status sub", rv, 8'h00);
        bus_rd(16'h01F2, rv); chk("R9 count sub", rv, 8'h00);
        bus_rd(16'h03F6, rv); chk("R9 alt status sub", rv, 8'h00);
        bus_rd(16'h03F7, rv); chk("R8 alt empty", rv, 8'hFF);
        bus_wr(16'h01F6, 8'h00);
        bus_rd(16'h01F6, rv); chk("R9 present again", rv, 8'hA0);
        bus_rd(16'h01F1, rv); chk("R6 abort kept", rv, 8'h05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule